// File: doc/BRIEF.md
# Opcode Trap Bus Substitution Gate

This block sits between the data pins of an 8-bit processor and the system data bus. On every read it forwards the system byte to the processor, with one exception. When the processor is fetching an opcode, marked by a fetch strobe that is high only in that cycle, and the fetched byte has both of its two lowest bits set, the gate withholds that byte. It presents an all-zero byte instead. The processor then decodes the software-interrupt opcode and enters its interrupt sequence. The handler reads the real byte back from memory with an ordinary data read, which the gate never alters. This lets software extend the instruction set through the 64 reserved codes.

Substitution is combinational on the strobe, the direction and the read byte, so it takes effect in the same bus cycle. A small cycle-classifying state machine records what kind of bus cycle has just completed. It raises a one-cycle trap pulse after each substituted fetch. Its states are ST_IDLE (reset, or a plain data read completed), ST_PASS_FETCH (an opcode fetch passed through), ST_TRAPPED (an opcode fetch was substituted) and ST_WROTE (a write cycle completed). Every state can move to every other state on each clock edge. The next state depends only on the kind of the current cycle: a substituted fetch goes to ST_TRAPPED, an unmodified fetch to ST_PASS_FETCH, a write to ST_WROTE, and a non-fetch read to ST_IDLE. Reset forces ST_IDLE.

Top module: `fetch_trap_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, trap_pulse is 0.
- R2: In a read cycle (rd_not_wr=1) with fetch_strobe=1, if sys_rdata bit 1 and bit 0 are both 1, cpu_rdata is 8'h00 in that same cycle, whatever the upper six bits hold.
- R3: In a read cycle with fetch_strobe=1, if sys_rdata bits [1:0] are not 2'b11, cpu_rdata equals sys_rdata in that cycle.
- R4: In a read cycle with fetch_strobe=0, cpu_rdata equals sys_rdata for every byte, including the reserved codes, and no trap pulse follows.
- R5: trap_pulse is 1 in the clock cycle that follows a substituted fetch, and 0 in the cycle that follows any other kind of bus cycle. Back-to-back substituted fetches give one pulse cycle each.
- R6: In a write cycle (rd_not_wr=0), sys_wdata equals cpu_wdata and sys_wdata_en is 1, and no substitution or trap pulse results even with fetch_strobe high. In a read cycle sys_wdata_en is 0.
- R7: A fetched genuine 8'h00 opcode reaches the processor as 8'h00 and is not followed by a trap pulse.
- R8: Each of the 64 codes whose low hex digit is 3, 7, B or F is substituted when fetched, and none of the other 192 codes is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_strobe | input | 1 | High only during an opcode fetch cycle |
| rd_not_wr | input | 1 | 1 for a read cycle, 0 for a write cycle |
| sys_rdata | input | 8 | Byte returned by the system bus |
| cpu_wdata | input | 8 | Byte driven by the processor on a write |
| cpu_rdata | output | 8 | Byte presented to the processor |
| sys_wdata | output | 8 | Byte driven onto the system bus |
| sys_wdata_en | output | 1 | System-side write drive enable |
| trap_pulse | output | 1 | One-cycle flag after each substituted fetch |

## Verification
On every clock the embedded assertions check four things: reserved fetches read as zero, non-fetch reads and unreserved fetches pass through unchanged, writes are forwarded with the drive enable set, and the trap pulse follows a substituted fetch and no other cycle. The bench alone shows the full code coverage. It sweeps all 256 byte values as fetches and as plain reads, which shows the 64-code trap class exactly and the handling of a genuine zero opcode. Its scenarios also show the reset state and back-to-back trap pulses, and a random mix of fetches, reads and writes against reference functions.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    // Kind of bus cycle seen at the processor pins
    typedef enum logic [1:0] {
        KIND_DATA_READ  = 2'd0,
        KIND_FETCH_PASS = 2'd1,
        KIND_FETCH_TRAP = 2'd2,
        KIND_WRITE      = 2'd3
    } cycle_kind_e;

    // States of the cycle-classifying machine (kind of cycle just completed)
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PASS_FETCH = 2'd1,
        ST_TRAPPED    = 2'd2,
        ST_WROTE      = 2'd3
    } gate_state_e;

endpackage

// File: rtl/ftg_classifier.sv
module ftg_classifier
    import ftg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TRAP_BITS = 2
) (
    input  logic              fetch_strobe,
    input  logic              rd_not_wr,
    input  logic [DATA_W-1:0] sys_rdata,
    output cycle_kind_e       kind
);
    localparam logic [TRAP_BITS-1:0] ALL_SET = '1;

    logic reserved;

    // Reserved class: every one of the low TRAP_BITS bits is set
    assign reserved = (sys_rdata[TRAP_BITS-1:0] == ALL_SET);

    always_comb begin
        if (!rd_not_wr) begin
            kind = KIND_WRITE;
        end else if (!fetch_strobe) begin
            kind = KIND_DATA_READ;
        end else if (reserved) begin
            kind = KIND_FETCH_TRAP;
        end else begin
            kind = KIND_FETCH_PASS;
        end
    end

endmodule

// File: rtl/ftg_data_path.sv
module ftg_data_path
    import ftg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SUB_CODE = '0
) (
    input  cycle_kind_e       kind,
    input  logic [DATA_W-1:0] sys_rdata,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_wdata_en
);
    always_comb begin
        cpu_rdata    = sys_rdata;
        sys_wdata    = cpu_wdata;
        sys_wdata_en = 1'b0;
        unique case (kind)
            KIND_FETCH_TRAP: cpu_rdata    = SUB_CODE;
            KIND_WRITE:      sys_wdata_en = 1'b1;
            KIND_DATA_READ,
            KIND_FETCH_PASS: cpu_rdata    = sys_rdata;
        endcase
    end

endmodule

// File: rtl/ftg_cycle_fsm.sv
module ftg_cycle_fsm
    import ftg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cycle_kind_e kind,
    output logic        trap_pulse
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (kind)
            KIND_FETCH_TRAP: state_d = ST_TRAPPED;
            KIND_FETCH_PASS: state_d = ST_PASS_FETCH;
            KIND_WRITE:      state_d = ST_WROTE;
            KIND_DATA_READ:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        trap_pulse = 1'b0;
        unique case (state_q)
            ST_TRAPPED:    trap_pulse = 1'b1;
            ST_IDLE,
            ST_PASS_FETCH,
            ST_WROTE:      trap_pulse = 1'b0;
        endcase
    end

    // R5
    trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_FETCH_TRAP) |=> trap_pulse);

    // R5
    no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != KIND_FETCH_TRAP) |=> !trap_pulse);

endmodule

// File: rtl/fetch_trap_gate.sv
module fetch_trap_gate
    import ftg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TRAP_BITS = 2,
    parameter logic [DATA_W-1:0] SUB_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_strobe,
    input  logic              rd_not_wr,
    input  logic [DATA_W-1:0] sys_rdata,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              sys_wdata_en,
    output logic              trap_pulse
);
    cycle_kind_e kind;

    ftg_classifier #(
        .DATA_W   (DATA_W),
        .TRAP_BITS(TRAP_BITS)
    ) u_classifier (
        .fetch_strobe(fetch_strobe),
        .rd_not_wr   (rd_not_wr),
        .sys_rdata   (sys_rdata),
        .kind        (kind)
    );

    ftg_data_path #(
        .DATA_W  (DATA_W),
        .SUB_CODE(SUB_CODE)
    ) u_data_path (
        .kind        (kind),
        .sys_rdata   (sys_rdata),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .sys_wdata   (sys_wdata),
        .sys_wdata_en(sys_wdata_en)
    );

    ftg_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .trap_pulse(trap_pulse)
    );

    // R2
    trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_not_wr && fetch_strobe && (&sys_rdata[TRAP_BITS-1:0]))
            |-> (cpu_rdata == SUB_CODE));

    // R3 R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_not_wr && !(fetch_strobe && (&sys_rdata[TRAP_BITS-1:0])))
            |-> (cpu_rdata == sys_rdata));

    // R6
    write_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_not_wr |-> (sys_wdata_en && (sys_wdata == cpu_wdata)));

    // R6
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_not_wr |-> !sys_wdata_en);

endmodule

// File: tb/test_fetch_trap_gate.sv
module test_fetch_trap_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_strobe = 1'b0;
    logic       rd_not_wr = 1'b1;
    logic [7:0] sys_rdata = 8'h00;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] sys_wdata;
    logic       sys_wdata_en;
    logic       trap_pulse;

    int tests_run = 0;
    int tests_failed = 0;
    bit exp_pulse = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_trap_gate i_fetch_trap_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_strobe(fetch_strobe),
        .rd_not_wr   (rd_not_wr),
        .sys_rdata   (sys_rdata),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .sys_wdata   (sys_wdata),
        .sys_wdata_en(sys_wdata_en),
        .trap_pulse  (trap_pulse)
    );

    function automatic bit ref_trap(input bit strobe, input bit rnw, input logic [7:0] d);
        return strobe && rnw && (d[1:0] == 2'b11);
    endfunction

    function automatic logic [7:0] ref_rdata(input bit strobe, input bit rnw, input logic [7:0] d);
        return ref_trap(strobe, rnw, d) ? 8'h00 : d;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check same-cycle outputs and the pulse of the previous cycle
    task automatic bus_cycle(input string req, input bit strobe, input bit rnw,
                             input logic [7:0] rd, input logic [7:0] wd);
        @(negedge clk);
        fetch_strobe = strobe;
        rd_not_wr    = rnw;
        sys_rdata    = rd;
        cpu_wdata    = wd;
        #1;
        check({req, " R5 pulse"}, {7'd0, trap_pulse}, {7'd0, exp_pulse});
        if (rnw) begin
            check({req, " rdata"}, cpu_rdata, ref_rdata(strobe, rnw, rd));
            check("R6 no drive on read", {7'd0, sys_wdata_en}, 8'h00);
        end else begin
            check("R6 wdata", sys_wdata, wd);
            check("R6 wdata_en", {7'd0, sys_wdata_en}, 8'h01);
        end
        exp_pulse = ref_trap(strobe, rnw, rd);
    endtask

    initial begin
        #150000;
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1980);
        // R1: reset state
        repeat (3) @(negedge clk);
        fetch_strobe = 1'b1;
        sys_rdata = 8'hFF;
        #1;
        check("R1 pulse in reset", {7'd0, trap_pulse}, 8'h00);
        @(negedge clk);
        fetch_strobe = 1'b0;
        sys_rdata = 8'h00;
        rst_n = 1'b1;
        #1;
        check("R1 pulse after reset", {7'd0, trap_pulse}, 8'h00);
        exp_pulse = 1'b0;

        // R7: genuine zero opcode
        bus_cycle("R7 zero fetch", 1'b1, 1'b1, 8'h00, 8'h00);
        bus_cycle("R7 after zero", 1'b0, 1'b1, 8'h00, 8'h00);

        // R8 R2 R3: every code fetched
        for (int i = 0; i < 256; i++) begin
            bus_cycle((i[1:0] == 2'b11) ? "R8 R2 trap" : "R8 R3 pass",
                      1'b1, 1'b1, 8'(i), 8'h00);
        end
        // R4: every code as a plain data read
        for (int i = 0; i < 256; i++) begin
            bus_cycle("R4 data read", 1'b0, 1'b1, 8'(i), 8'h00);
        end

        // R5: back-to-back traps then a pass fetch
        bus_cycle("R5 b2b a", 1'b1, 1'b1, 8'h03, 8'h00);
        bus_cycle("R5 b2b b", 1'b1, 1'b1, 8'hFB, 8'h00);
        bus_cycle("R5 b2b c", 1'b1, 1'b1, 8'h42, 8'h00);
        bus_cycle("R5 tail",  1'b0, 1'b1, 8'h77, 8'h00);

        // R6: write with strobe high and reserved read byte
        bus_cycle("R6 write strobe", 1'b1, 1'b0, 8'hFF, 8'hA5);
        bus_cycle("R6 after write", 1'b0, 1'b1, 8'h13, 8'h00);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            bit s, r;
            logic [7:0] d, w;
            s = 1'($urandom);
            r = ($urandom % 4) != 0;
            d = 8'($urandom);
            w = 8'($urandom);
            bus_cycle("R2 R3 R4 R6 random", s, r, d, w);
        end
        bus_cycle("R5 final", 1'b0, 1'b1, 8'h00, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule